// File: doc/BRIEF.md
# Unsigned Divide Unit with HI/LO Result Registers

This unit executes the unsigned divide instruction of a 64-bit RISC core that also runs a 32-bit compatibility mode. The pipeline presents the decoded instruction word, a start pulse and the two source register values. The unit checks that the word really is the unsigned divide and exposes the two source register indices so the register file can be read. It then runs a restoring shift-subtract divider that produces one quotient bit per clock. When the divider finishes, the quotient goes to the special register LO and the remainder goes to HI, both in the same cycle. No exception is ever raised.

Only the low 32 bits of each operand take part in the division. In 64-bit mode each 32-bit result is sign-extended from its bit 31 to fill the register. In 32-bit mode the upper half of each register is zero. A zero divisor gives a fixed result: an all-ones quotient and the dividend as the remainder. Software must leave at least two instructions between a read of HI or LO and a following divide. The unit does not detect a violation of that rule.

The control is a three-state machine. `ST_IDLE` waits for a start. Start with a recognised instruction takes `ST_IDLE -> ST_RUN`, which loads the operands. `ST_RUN` stays in `ST_RUN` for 31 more iterations. After the 32nd iteration, `ST_RUN -> ST_WRITE` is taken. `ST_WRITE -> ST_IDLE` updates HI and LO. Any other start leaves the unit in `ST_IDLE`.

Top module: `udiv_hilo`

## Requirements
- R1: A start is accepted only when the instruction word has bits 31..26 = 000000, bits 15..6 = 0 and bits 5..0 = 011011. Any other word leaves busy low and HI and LO unchanged.
- R2: `src_a_idx` always shows instruction bits 25..21 and `src_b_idx` always shows bits 20..16. The first operand is the dividend and the second is the divisor.
- R3: Both operands are unsigned. The quotient is written to `lo_q` and the remainder to `hi_q`.
- R4: When `mode64` is 1, only the low 32 bits of the operands are used, and each 32-bit result is sign-extended from its bit 31 to 64 bits.
- R5: When `mode64` is 0, only the low 32 bits of the operands are used, and bits 63..32 of `hi_q` and `lo_q` are zero.
- R6: With a low 32-bit divisor of zero, the 32-bit quotient is all ones and the remainder equals the low 32 bits of the dividend. Both are extended as in R4 or R5.
- R7: `busy` goes high on the clock edge that accepts a start. It stays high for exactly 33 cycles and falls on the same edge that updates HI and LO.
- R8: A start while `busy` is high is ignored. The running division completes on time with its own operands.
- R9: HI and LO change only on the final edge of a division and keep their value at all other times.
- R10: After reset, `busy` is low and `hi_q` and `lo_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue pulse for the instruction in `insn` |
| insn | input | 32 | Instruction word |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode; must be held while busy |
| opnd_a | input | 64 | Dividend register value |
| opnd_b | input | 64 | Divisor register value |
| src_a_idx | output | 5 | Dividend register index |
| src_b_idx | output | 5 | Divisor register index |
| busy | output | 1 | Division in progress |
| hi_q | output | 64 | HI register (remainder) |
| lo_q | output | 64 | LO register (quotient) |

## Verification
The checker assumes that `mode64` is held steady from the accepted start until `busy` falls. Its result-width properties read the mode at that final edge. It also assumes that operands are only sampled at the accepting edge, so later changes to them are harmless. The stimulus changes `mode64` only while the unit is idle. It deliberately changes the operands and pulses start in the middle of a division to exercise R8.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_WRITE = 2'd2
    } div_state_e;

    localparam int unsigned INSN_W     = 32;
    localparam int unsigned REG_IDX_W  = 5;
    localparam logic [5:0]  OPC_SPECIAL = 6'b000000;
    localparam logic [5:0]  FN_DIVU     = 6'b011011;
endpackage

// File: rtl/udiv_decode.sv
module udiv_decode
    import udiv_pkg::*;
(
    input  logic [INSN_W-1:0]    insn,
    output logic                 is_divu,
    output logic [REG_IDX_W-1:0] idx_a,
    output logic [REG_IDX_W-1:0] idx_b
);
    logic opc_ok, pad_ok, fn_ok;

    always_comb begin
        opc_ok  = (insn[31:26] == OPC_SPECIAL);
        pad_ok  = (insn[15:6] == '0);
        fn_ok   = (insn[5:0] == FN_DIVU);
        is_divu = opc_ok && pad_ok && fn_ok;
        idx_a   = insn[25:21];
        idx_b   = insn[20:16];
    end
endmodule

// File: rtl/udiv_engine.sv
module udiv_engine #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem
);
    logic [DW-1:0] dsr_q;
    logic [DW:0]   partial;
    logic [DW:0]   diff;
    logic          qbit;
    logic [DW-1:0] rem_nxt;

    // one restoring iteration: shift in next dividend bit, trial subtract
    always_comb begin
        partial = {rem, quo[DW-1]};
        diff    = partial - {1'b0, dsr_q};
        qbit    = ~diff[DW];
        rem_nxt = qbit ? diff[DW-1:0] : partial[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo   <= '0;
            rem   <= '0;
            dsr_q <= '0;
        end else if (load) begin
            quo   <= dividend;
            rem   <= '0;
            dsr_q <= divisor;
        end else if (step) begin
            quo <= {quo[DW-2:0], qbit};
            rem <= rem_nxt;
        end
    end
endmodule

// File: rtl/udiv_extend.sv
module udiv_extend #(
    parameter int unsigned DW = 32,
    parameter int unsigned RW = 64
) (
    input  logic          sext,
    input  logic [DW-1:0] val,
    output logic [RW-1:0] ext
);
    localparam int unsigned PADW = RW - DW;

    always_comb begin
        ext = sext ? {{PADW{val[DW-1]}}, val} : {{PADW{1'b0}}, val};
    end
endmodule

// File: rtl/udiv_hilo.sv
module udiv_hilo
    import udiv_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned RW = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [INSN_W-1:0]    insn,
    input  logic                 mode64,
    input  logic [RW-1:0]        opnd_a,
    input  logic [RW-1:0]        opnd_b,
    output logic [REG_IDX_W-1:0] src_a_idx,
    output logic [REG_IDX_W-1:0] src_b_idx,
    output logic                 busy,
    output logic [RW-1:0]        hi_q,
    output logic [RW-1:0]        lo_q
);
    localparam int unsigned CW   = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    div_state_e    state, state_nxt;
    logic          is_divu;
    logic          accept;
    logic          load, step, wr_en;
    logic [CW-1:0] iter;
    logic          mode_q;
    logic [DW-1:0] quo, rem;
    logic [RW-1:0] quo_ext, rem_ext;
    logic          unused_upper;

    assign unused_upper = ^{opnd_a[RW-1:DW], opnd_b[RW-1:DW]};

    udiv_decode u_dec (
        .insn    (insn),
        .is_divu (is_divu),
        .idx_a   (src_a_idx),
        .idx_b   (src_b_idx)
    );

    assign accept = start && is_divu;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nxt = ST_RUN;
            ST_RUN:   if (iter == LAST) state_nxt = ST_WRITE;
            ST_WRITE: state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // outputs of the machine
    always_comb begin
        load  = 1'b0;
        step  = 1'b0;
        wr_en = 1'b0;
        busy  = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                load = accept;
            end
            ST_RUN:   step  = 1'b1;
            ST_WRITE: wr_en = 1'b1;
            default:  busy  = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter   <= '0;
            mode_q <= 1'b0;
        end else if (load) begin
            iter   <= '0;
            mode_q <= mode64;
        end else if (step) begin
            iter <= iter + 1'b1;
        end
    end

    udiv_engine #(.DW(DW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .dividend (opnd_a[DW-1:0]),
        .divisor  (opnd_b[DW-1:0]),
        .quo      (quo),
        .rem      (rem)
    );

    udiv_extend #(.DW(DW), .RW(RW)) u_ext_lo (
        .sext (mode_q),
        .val  (quo),
        .ext  (quo_ext)
    );

    udiv_extend #(.DW(DW), .RW(RW)) u_ext_hi (
        .sext (mode_q),
        .val  (rem),
        .ext  (rem_ext)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (wr_en) begin
            hi_q <= rem_ext;
            lo_q <= quo_ext;
        end
    end
endmodule

// File: rtl/udiv_hilo_chk.sv
module udiv_hilo_chk #(
    parameter int unsigned DW = 32,
    parameter int unsigned RW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [31:0]   insn,
    input logic          mode64,
    input logic          busy,
    input logic [RW-1:0] hi_q,
    input logic [RW-1:0] lo_q
);
    localparam int unsigned LAT = DW + 1;

    logic       word_ok;
    logic [7:0] busy_cnt;

    assign word_ok = (insn[31:26] == 6'b0) && (insn[15:6] == 10'b0) && (insn[5:0] == 6'b011011);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    // R1 / R7: an accepted word raises busy, any other start does not
    a_r7_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && word_ok) |=> busy);
    a_r1_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && word_ok)) |=> (!busy && $stable(hi_q) && $stable(lo_q)));
    // R7: exact busy length
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == 8'(LAT)));
    // R8 / R9: results held while running
    a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || ($stable(hi_q) && $stable(lo_q))));
    // R5: upper halves zero in 32-bit mode
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !mode64) |-> (hi_q[RW-1:DW] == '0 && lo_q[RW-1:DW] == '0));
    // R4: upper halves copy bit 31 in 64-bit mode
    a_r4_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && mode64) |->
        (hi_q[RW-1:DW] == {(RW-DW){hi_q[DW-1]}} && lo_q[RW-1:DW] == {(RW-DW){lo_q[DW-1]}}));
endmodule

bind udiv_hilo udiv_hilo_chk #(.DW(DW), .RW(RW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .insn   (insn),
    .mode64 (mode64),
    .busy   (busy),
    .hi_q   (hi_q),
    .lo_q   (lo_q)
);

// File: tb/udiv_hilo_bench.sv
`timescale 1ns/1ps
module udiv_hilo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic        mode64 = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [4:0]  src_a_idx, src_b_idx;
    logic        busy;
    logic [63:0] hi_q, lo_q;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [127:0] sb_q[$];
    string        sb_tag[$];
    logic [63:0]  last_hi = '0;
    logic [63:0]  last_lo = '0;

    always #2.5 clk = ~clk;

    udiv_hilo u_udiv_hilo (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .mode64(mode64),
        .opnd_a(opa), .opnd_b(opb), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .busy(busy), .hi_q(hi_q), .lo_q(lo_q)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic logic [31:0] mk_insn(input logic [4:0] ra, input logic [4:0] rb);
        return {6'b000000, ra, rb, 10'b0, 6'b011011};
    endfunction

    function automatic logic [63:0] widen(input logic [31:0] v, input logic m);
        return m ? {{32{v[31]}}, v} : {32'b0, v};
    endfunction

    // driver: issue one divide, push expectation, time busy
    task automatic run_div(input logic [4:0] ra, input logic [4:0] rb, input logic [63:0] a,
                           input logic [63:0] b, input logic m, input bit disturb, input string tag);
        logic [31:0] a32, b32, q32, r32;
        int n;
        a32 = a[31:0];
        b32 = b[31:0];
        q32 = (b32 == 0) ? 32'hFFFF_FFFF : a32 / b32;
        r32 = (b32 == 0) ? a32 : a32 % b32;
        @(negedge clk);
        insn = mk_insn(ra, rb); opa = a; opb = b; mode64 = m; start = 1'b1;
        #0.1;
        check(src_a_idx == ra, "R2 idx_a", {59'b0, src_a_idx}, {59'b0, ra});
        check(src_b_idx == rb, "R2 idx_b", {59'b0, src_b_idx}, {59'b0, rb});
        sb_q.push_back({widen(r32, m), widen(q32, m)});
        sb_tag.push_back(tag);
        last_hi = widen(r32, m);
        last_lo = widen(q32, m);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7 busy rise", {63'b0, busy}, 64'd1);
        n = 0;
        while (busy && n < 100) begin
            n++;
            if (disturb && n == 5) begin
                opa = ~a; opb = 64'd3; start = 1'b1;   // R8 mid-run start
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(n == 33, disturb ? "R8 busy length" : "R7 busy length", 64'(n), 64'd33);
    endtask

    // R1: non-matching word must be ignored
    task automatic bad_word(input logic [31:0] w, input string tag);
        @(negedge clk);
        insn = w; opa = 64'd77; opb = 64'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, {tag, " busy"}, {63'b0, busy}, 64'd0);
        repeat (3) @(negedge clk);
        check(hi_q == last_hi, {tag, " hi held (R9)"}, hi_q, last_hi);
        check(lo_q == last_lo, {tag, " lo held (R9)"}, lo_q, last_lo);
    endtask

    // monitor: compare at the edge where busy falls
    initial begin
        logic prev_busy;
        logic [127:0] e;
        string t;
        prev_busy = 1'b0;
        forever begin
            @(negedge clk);
            if (prev_busy && !busy) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9 unexpected result", hi_q, 64'd0);
                end else begin
                    e = sb_q.pop_front();
                    t = sb_tag.pop_front();
                    check(hi_q == e[127:64], {t, " HI remainder"}, hi_q, e[127:64]);
                    check(lo_q == e[63:0], {t, " LO quotient"}, lo_q, e[63:0]);
                end
            end
            prev_busy = busy;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10 busy", {63'b0, busy}, 64'd0);
        check(hi_q == 64'd0, "R10 hi", hi_q, 64'd0);
        check(lo_q == 64'd0, "R10 lo", lo_q, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_div(5'd3, 5'd4, 64'd100, 64'd7, 1'b0, 0, "R3 small");
        run_div(5'd31, 5'd0, 64'd5, 64'd9, 1'b0, 0, "R3 a<b");
        run_div(5'd1, 5'd2, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b1, 0, "R4 max/1");
        run_div(5'd7, 5'd8, 64'h0000_0000_8000_0000, 64'd3, 1'b1, 0, "R4 top bit");
        run_div(5'd9, 5'd10, 64'hDEAD_BEEF_0000_1234, 64'h1234_5678_0000_0010, 1'b1, 0, "R4 low bits only");
        run_div(5'd9, 5'd10, 64'hDEAD_BEEF_0000_1234, 64'h1234_5678_0000_0010, 1'b0, 0, "R5 low bits only");
        run_div(5'd11, 5'd12, 64'h0000_0000_FFFF_FFFE, 64'h0000_0000_FFFF_FFFF, 1'b1, 0, "R4 rem sext");
        run_div(5'd11, 5'd12, 64'h0000_0000_FFFF_FFFE, 64'h0000_0000_FFFF_FFFF, 1'b0, 0, "R5 rem zext");
        run_div(5'd13, 5'd14, 64'h0000_0000_9ABC_DEF0, 64'hFFFF_FFFF_0000_0000, 1'b1, 0, "R6 zero div 64");
        run_div(5'd13, 5'd14, 64'h0000_0000_1357_9BDF, 64'd0, 1'b0, 0, "R6 zero div 32");
        run_div(5'd15, 5'd16, 64'h0000_0000_ABCD_0123, 64'd1000, 1'b0, 1, "R8 start while busy");

        bad_word(32'h0000_001A, "R1 wrong function");
        bad_word(32'h0000_005B, "R1 nonzero pad");
        bad_word(32'h0400_001B, "R1 wrong opcode");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R3 scoreboard drained", 64'(sb_q.size()), 64'd0);
        finish_run();
    end
endmodule